// File: doc/BRIEF.md
# Pipelined Prefix Carry-Lookahead Adder

This block adds two unsigned operands of a power-of-two width (16 bits by default) and returns the sum together with a carry-out. Each bit position is first classified into a two-bit carry status that says whether the carry leaving that position is forced to zero (kill), forced to one (generate), or equal to the carry entering it (propagate). A kill status sits in front of bit 0 as a seed, so the carry into bit 0 is zero.

A parallel prefix over these statuses produces every carry. It uses recursive doubling: in level d each element merges with the element 2^d positions below it, so log2(width+1), rounded up, levels cover the seed and every bit. A register sits after every level. Because the seed is kill, each finished prefix is either kill or generate, and that value is the carry. The XOR of the operands travels down the pipeline beside the statuses, and the last stage forms the sum and registers it.

Operands enter under a valid strobe, and results leave under a matching strobe at a fixed latency. There is no backpressure, and a new pair may be accepted on every clock.

Top module: `cla_prefix_adder`

## Requirements
- R1: The status of bit j is encoded 00 (kill) when both operand bits are 0, 11 (generate) when both are 1, and 01 (propagate) when they differ. The seed element in front of bit 0 is 00.
- R2: Code 10 never appears in any element of any pipeline stage.
- R3: When `out_valid` is high, `out_sum` equals (`in_a` + `in_b`) mod 2^WIDTH and `out_carry` equals bit WIDTH of the full sum, for the operands accepted with that result.
- R4: A result appears on the rising edge that comes LVLS edges after the edge that samples `in_valid` high, where LVLS = ceil(log2(WIDTH+1)). The total register depth is LVLS+1, and `out_valid` is `in_valid` delayed by exactly that much.
- R5: Operand pairs offered on consecutive cycles are all accepted. Their results leave on consecutive cycles in the order the pairs were offered.
- R6: On the first cycle after reset is released, `out_valid`, `out_sum` and `out_carry` are 0.
- R7: The carry chain spans the full width: all-ones + 1 gives a sum of 0 with `out_carry` 1, and 0 + 0 gives 0 with no carry, because the carry into bit 0 is zero.
- R8: While `out_valid` is low, `out_sum` and `out_carry` keep their last value. Operands presented with `in_valid` low produce no result.
- R9: Every element of the final prefix stage is kill or generate, never propagate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair valid this cycle |
| in_a | input | WIDTH | First unsigned operand |
| in_b | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | Result valid this cycle |
| out_sum | output | WIDTH | Sum modulo 2^WIDTH |
| out_carry | output | 1 | Carry out of the top bit |

## Verification
In the same cycle, the block can accept a new operand pair at its input and deliver an older result at its output. Several pairs also share the prefix levels, each in a different stage. An exhaustive sweep of every operand pair of an 8-bit instance is streamed back to back to provoke this. Each result is judged against an arithmetic sum held in a small queue and against the edge count since its pair was sampled. Directed pairs with idle gaps between them, carrying junk operands, check that the outputs hold and that no spurious result leaves.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Two-bit carry status; the value 10 is never legal.
    typedef enum logic [1:0] {
        CS_KILL = 2'b00,
        CS_PROP = 2'b01,
        CS_GEN  = 2'b11
    } cstat_e;

    localparam logic [1:0] CS_ILLEGAL = 2'b10;

    // Classify one bit position from its two operand bits.
    function automatic logic [1:0] classify(input logic a, input logic b);
        cstat_e s;
        if (a & b)
            s = CS_GEN;
        else if (a ^ b)
            s = CS_PROP;
        else
            s = CS_KILL;
        return s;
    endfunction

    // Merge a lower span (lo) with the span directly above it (hi).
    function automatic logic [1:0] combine(input logic [1:0] lo, input logic [1:0] hi);
        return (hi == CS_PROP) ? lo : hi;
    endfunction

    // A finished prefix is kill or generate; generate means carry one.
    function automatic logic carry_of(input logic [1:0] y);
        return (y == CS_GEN);
    endfunction

    // Doubling levels needed for the seed plus WIDTH bit elements.
    function automatic int prefix_levels(input int width);
        return $clog2(width + 1);
    endfunction

endpackage

// File: rtl/cla_status_gen.sv
module cla_status_gen
    import cla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]      a_i,
    input  logic [WIDTH-1:0]      b_i,
    output logic [WIDTH:0][1:0]   st_o,
    output logic [WIDTH-1:0]      px_o
);

    // Element 0 is the fixed kill seed ahead of bit 0.
    assign st_o[0] = CS_KILL;

    for (genvar j = 0; j < WIDTH; j++) begin : g_bit
        assign st_o[j+1] = classify(a_i[j], b_i[j]);
    end

    assign px_o = a_i ^ b_i;

endmodule

// File: rtl/cla_prefix_level.sv
module cla_prefix_level
    import cla_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DIST  = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic [WIDTH:0][1:0]  st_i,
    input  logic [WIDTH-1:0]     px_i,
    output logic                 vld_o,
    output logic [WIDTH:0][1:0]  st_o,
    output logic [WIDTH-1:0]     px_o
);

    localparam int ELEMS = WIDTH + 1;

    logic [WIDTH:0][1:0] st_next;

    for (genvar e = 0; e < ELEMS; e++) begin : g_elem
        if (e >= DIST) begin : g_merge
            assign st_next[e] = combine(st_i[e-DIST], st_i[e]);
        end else begin : g_pass
            assign st_next[e] = st_i[e];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            st_o  <= '0;
            px_o  <= '0;
        end else begin
            vld_o <= vld_i;
            st_o  <= st_next;
            px_o  <= px_i;
        end
    end

endmodule

// File: rtl/cla_sum_stage.sv
module cla_sum_stage
    import cla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic [WIDTH:0][1:0]  st_i,
    input  logic [WIDTH-1:0]     px_i,
    output logic                 vld_o,
    output logic [WIDTH-1:0]     sum_o,
    output logic                 carry_o
);

    logic [WIDTH-1:0] carry_in;

    // Prefix of element j covers the seed and bits below j: carry into bit j.
    for (genvar j = 0; j < WIDTH; j++) begin : g_carry
        assign carry_in[j] = carry_of(st_i[j]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o   <= 1'b0;
            sum_o   <= '0;
            carry_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                sum_o   <= px_i ^ carry_in;
                carry_o <= carry_of(st_i[WIDTH]);
            end
        end
    end

endmodule

// File: rtl/cla_prefix_adder.sv
module cla_prefix_adder
    import cla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_carry
);

    localparam int LVLS = prefix_levels(WIDTH);

    logic [WIDTH:0][1:0] stage_st  [LVLS+1];
    logic [WIDTH-1:0]    stage_px  [LVLS+1];
    logic                stage_vld [LVLS+1];

    cla_status_gen #(.WIDTH(WIDTH)) u_gen (
        .a_i  (in_a),
        .b_i  (in_b),
        .st_o (stage_st[0]),
        .px_o (stage_px[0])
    );

    assign stage_vld[0] = in_valid;

    for (genvar g = 0; g < LVLS; g++) begin : g_level
        cla_prefix_level #(
            .WIDTH (WIDTH),
            .DIST  (1 << g)
        ) u_lvl (
            .clk   (clk),
            .rst   (rst),
            .vld_i (stage_vld[g]),
            .st_i  (stage_st[g]),
            .px_i  (stage_px[g]),
            .vld_o (stage_vld[g+1]),
            .st_o  (stage_st[g+1]),
            .px_o  (stage_px[g+1])
        );
    end

    cla_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .clk     (clk),
        .rst     (rst),
        .vld_i   (stage_vld[LVLS]),
        .st_i    (stage_st[LVLS]),
        .px_i    (stage_px[LVLS]),
        .vld_o   (out_valid),
        .sum_o   (out_sum),
        .carry_o (out_carry)
    );

endmodule

// File: rtl/cla_prefix_adder_chk.sv
module cla_prefix_adder_chk
    import cla_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int LVLS  = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [WIDTH-1:0]     in_a,
    input logic [WIDTH-1:0]     in_b,
    input logic                 out_valid,
    input logic [WIDTH-1:0]     out_sum,
    input logic                 out_carry,
    input logic [WIDTH:0][1:0]  stage_st [LVLS+1]
);

    localparam int LAT = LVLS + 1;

    logic [LAT-1:0] vld_sr;
    logic [WIDTH:0] exp_sr [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sr <= '0;
            for (int k = 0; k < LAT; k++) exp_sr[k] <= '0;
        end else begin
            vld_sr <= {vld_sr[LAT-2:0], in_valid};
            if (in_valid) exp_sr[0] <= {1'b0, in_a} + {1'b0, in_b};
            for (int k = 1; k < LAT; k++) exp_sr[k] <= exp_sr[k-1];
        end
    end

    logic enc_bad;
    logic code_bad;
    logic final_prop;

    always_comb begin
        enc_bad = (stage_st[0][0] != 2'b00);
        for (int j = 0; j < WIDTH; j++)
            if (stage_st[0][j+1] != {in_a[j] & in_b[j], in_a[j] | in_b[j]}) enc_bad = 1'b1;
    end

    always_comb begin
        code_bad = 1'b0;
        for (int s = 0; s <= LVLS; s++)
            for (int e = 0; e <= WIDTH; e++)
                if (stage_st[s][e] == CS_ILLEGAL) code_bad = 1'b1;
    end

    always_comb begin
        final_prop = 1'b0;
        for (int e = 0; e <= WIDTH; e++)
            if (stage_st[LVLS][e] == 2'b01) final_prop = 1'b1;
    end

    // R1
    status_enc_chk: assert property (@(posedge clk) disable iff (rst) !enc_bad);

    // R2
    no_illegal_code_chk: assert property (@(posedge clk) disable iff (rst) !code_bad);

    // R9
    final_no_prop_chk: assert property (@(posedge clk) disable iff (rst) !final_prop);

    // R3
    sum_value_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ({out_carry, out_sum} == exp_sr[LAT-1]));

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == vld_sr[LAT-1]);

    // R6
    reset_out_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_sum == '0 && !out_carry));

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable({out_carry, out_sum}));

endmodule

bind cla_prefix_adder cla_prefix_adder_chk #(
    .WIDTH (WIDTH),
    .LVLS  (LVLS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_carry (out_carry),
    .stage_st  (stage_st)
);

// File: tb/cla_prefix_adder_tb.sv
module cla_prefix_adder_tb;

    localparam int W     = 8;
    localparam int EDGES = $clog2(W + 1);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_sum;
    logic         out_carry;

    always #5 clk = ~clk;

    cla_prefix_adder #(.WIDTH(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_carry (out_carry)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    logic [W:0] exp_q   [16];
    int         stamp_q [16];
    int         wr = 0;
    int         rd = 0;
    logic [W:0] last_out = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input int gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_a     = a;
        in_b     = b;
        exp_q[wr % 16]   = {1'b0, a} + {1'b0, b};
        stamp_q[wr % 16] = cyc + 1;
        wr++;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_a     = W'($urandom);
            in_b     = W'($urandom);
        end
    endtask

    // Monitor: outputs change at posedge, sampled at negedge.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (rd == wr) begin
                    chk(1'b0, "R8 result without accepted pair", 32'(out_sum), 32'hx);
                end else begin
                    chk({out_carry, out_sum} == exp_q[rd % 16], "R1 R2 R3 R7 R9 sum/carry",
                        32'({out_carry, out_sum}), 32'(exp_q[rd % 16]));
                    chk((cyc - stamp_q[rd % 16]) == EDGES, "R4 R5 latency in edges",
                        32'(cyc - stamp_q[rd % 16]), 32'(EDGES));
                    rd++;
                end
                last_out = {out_carry, out_sum};
            end else begin
                chk({out_carry, out_sum} == last_out, "R8 hold while idle",
                    32'({out_carry, out_sum}), 32'(last_out));
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 out_valid after reset", 32'(out_valid), 32'h0);
        chk(out_sum == '0, "R6 out_sum after reset", 32'(out_sum), 32'h0);
        chk(out_carry == 1'b0, "R6 out_carry after reset", 32'(out_carry), 32'h0);

        // R7 full-width carry chain and zero carry into bit 0
        send(8'hFF, 8'h01, 3);
        send(8'h00, 8'h00, 2);
        // Alternating patterns, with gaps and back to back (R5, R8)
        send(8'h55, 8'hAA, 1);
        send(8'hAA, 8'hAA, 0);
        send(8'h55, 8'h55, 4);
        send(8'hFF, 8'hFF, 2);
        send(8'h01, 8'hFF, 0);
        send(8'h80, 8'h80, 6);

        // Exhaustive sweep, one pair per cycle (R3, R5)
        for (int i = 0; i < 65536; i++) send(i[15:8], i[7:0], 0);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(rd == wr, "R5 every accepted pair delivered", 32'(rd), 32'(wr));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule